// File: doc/BRIEF.md
# Pseudo-Associative Serial Lookup Cache

This block is a small read cache that gets set associativity out of a single direct-mapped store of `BLOCKS` one-word lines. The store is split into `BLOCKS/WAYS` sets. A lookup does not compare every way of the set at once. It probes one way per cycle. The probe index is the way number placed above the low set bits of the address, so the block probes `{0,set}`, then `{1,set}`, and so on up to `{WAYS-1,set}`. It stops at the first probe whose stored tag matches.

When every probe misses, the cache asks the next level for the word and holds that request until the word arrives. It writes the word into the first empty way of the set. If no way is empty, it overwrites way 0. A hit found by a later probe moves the line into way 0, and the line that was in way 0 moves to the slot the hit came from. The next access to the same address then hits on the first probe. Every response reports whether it hit and how many probes it used, so the caller can measure the cost of serial lookup.

The processor side takes one request at a time through a ready/valid handshake and returns a single-cycle response pulse.

Top module: `psa_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0, and every line is empty, so the first access to any address is a full miss.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 until the response has been produced.
- R3: A hit on probe number i (probes counted from 1) raises `resp_valid` for one cycle, exactly i cycles after the accepting edge, with `resp_hit`=1 and `resp_probes`=i.
- R4: When all `WAYS` probes miss, `mem_req` becomes 1 exactly `WAYS` cycles after acceptance, with `mem_addr` equal to the request address. Both stay unchanged until `mem_valid` is seen.
- R5: On the edge where `mem_valid` is 1 during a fill, the next cycle shows `resp_valid`=1, `resp_hit`=0, `resp_probes`=`WAYS` and `resp_data` equal to `mem_data`, and `mem_req` returns to 0.
- R6: A fill goes into the lowest-numbered empty way of the set. If the set has no empty way, it goes into way 0.
- R7: A hit on probe i>1 exchanges that line with the line in way 0 of the same set, so the next access to that address hits on probe 1.
- R8: The stored tag holds every address bit above the set index, so two addresses that share a set but differ in any upper bit never hit on each other's line.
- R9: The set is given by the low log2(BLOCKS/WAYS) address bits. An access to one set never changes the lines of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 when the response came from a hit |
| resp_data | output | DATA_W | Returned word |
| resp_probes | output | $clog2(WAYS)+1 | Number of probes the access used |
| mem_req | output | 1 | Fill request to the next level, held until answered |
| mem_addr | output | ADDR_W | Address of the requested fill |
| mem_valid | input | 1 | Next level returns the fill word |
| mem_data | input | DATA_W | Fill word |

## Verification
The bench follows one set through the following cases:
- **Promotion from every probe depth.** A design that skips the swap, or swaps the wrong slot, shows up as a probe count that does not drop to 1 on the next access.
- **Eviction once the set is full.** If eviction were not pinned to way 0, the miss sequence that follows would fill slots that the bench expects to be empty.
- **Two addresses that share a set but differ only in high bits.** A design that stored a shortened tag would report a false hit.
- **Off-by-one latency.** Latency is counted cycle by cycle, so a design that declared a full miss one probe early or late would show the wrong `mem_req` timing.
- **Fill handshake.** A design that dropped `mem_req` or changed `mem_addr` before `mem_valid` would fail the hold checks.

// File: rtl/psa_pkg.sv
package psa_pkg;
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_LOOKUP = 2'd1,
        PS_FILL   = 2'd2
    } psa_state_e;
endpackage

// File: rtl/psa_probe.sv
// Forms the probe index from the way number and set bits, and compares tags.
module psa_probe #(
    parameter int ADDR_W = 12,
    parameter int SET_W  = 2,
    parameter int WAY_W  = 2,
    localparam int TAG_W = ADDR_W - SET_W,
    localparam int IDX_W = WAY_W + SET_W
) (
    input  logic [WAY_W-1:0]  way,
    input  logic [ADDR_W-1:0] addr,
    input  logic              line_valid,
    input  logic [TAG_W-1:0]  line_tag,
    output logic [IDX_W-1:0]  idx,
    output logic              match
);
    always_comb begin
        idx   = {way, addr[SET_W-1:0]};
        match = line_valid && (line_tag == addr[ADDR_W-1:SET_W]);
    end
endmodule

// File: rtl/psa_victim_pick.sv
// Lowest-numbered empty way, or way 0 when the set is full.
module psa_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_vec,
    output logic [WAY_W-1:0] way
);
    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/psa_cache.sv
module psa_cache
    import psa_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BLOCKS = 16,
    parameter int WAYS   = 4,
    localparam int SETS  = BLOCKS / WAYS,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = WAY_W + SET_W,
    localparam int TAG_W = ADDR_W - SET_W,
    localparam int CNT_W = WAY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic [CNT_W-1:0]  resp_probes,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        psa_state_e               st;
        logic [ADDR_W-1:0]        addr;
        logic [WAY_W-1:0]         way;
        logic [WAY_W-1:0]         victim;
        logic                     resp_valid;
        logic                     resp_hit;
        logic [DATA_W-1:0]        resp_data;
        logic [CNT_W-1:0]         resp_probes;
        logic                     mem_req;
        line_t [BLOCKS-1:0]       lines;
    } state_t;

    state_t q, d;

    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] fill_idx;
    logic             cur_match;
    logic [WAYS-1:0]  set_valid;
    logic [WAY_W-1:0] pick_way;
    line_t            cur_line;

    assign cur_line = q.lines[cur_idx];
    assign head_idx = {WAY_W'(0), q.addr[SET_W-1:0]};
    assign fill_idx = {q.victim, q.addr[SET_W-1:0]};

    psa_probe #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_probe (
        .way        (q.way),
        .addr       (q.addr),
        .line_valid (cur_line.valid),
        .line_tag   (cur_line.tag),
        .idx        (cur_idx),
        .match      (cur_match)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_setv
        assign set_valid[w] = q.lines[{WAY_W'(w), q.addr[SET_W-1:0]}].valid;
    end

    psa_victim_pick #(.WAYS(WAYS)) u_pick (
        .valid_vec (set_valid),
        .way       (pick_way)
    );

    always_comb begin
        d = q;
        d.resp_valid = 1'b0;
        unique case (q.st)
            PS_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.way  = '0;
                    d.st   = PS_LOOKUP;
                end
            end
            PS_LOOKUP: begin
                if (cur_match) begin
                    d.resp_valid  = 1'b1;
                    d.resp_hit    = 1'b1;
                    d.resp_data   = cur_line.data;
                    d.resp_probes = CNT_W'(q.way) + CNT_W'(1);
                    d.st          = PS_IDLE;
                    if (q.way != '0) begin
                        d.lines[head_idx] = cur_line;
                        d.lines[cur_idx]  = q.lines[head_idx];
                    end
                end else if (q.way == WAY_W'(WAYS - 1)) begin
                    d.victim  = pick_way;
                    d.mem_req = 1'b1;
                    d.st      = PS_FILL;
                end else begin
                    d.way = q.way + WAY_W'(1);
                end
            end
            PS_FILL: begin
                if (mem_valid) begin
                    d.mem_req               = 1'b0;
                    d.lines[fill_idx].valid = 1'b1;
                    d.lines[fill_idx].tag   = q.addr[ADDR_W-1:SET_W];
                    d.lines[fill_idx].data  = mem_data;
                    d.resp_valid            = 1'b1;
                    d.resp_hit              = 1'b0;
                    d.resp_data             = mem_data;
                    d.resp_probes           = CNT_W'(WAYS);
                    d.st                    = PS_IDLE;
                end
            end
            default: d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready   = (q.st == PS_IDLE);
    assign resp_valid  = q.resp_valid;
    assign resp_hit    = q.resp_hit;
    assign resp_data   = q.resp_data;
    assign resp_probes = q.resp_probes;
    assign mem_req     = q.mem_req;
    assign mem_addr    = q.addr;
endmodule

// File: rtl/psa_cache_chk.sv
module psa_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int WAYS   = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [CNT_W-1:0]  resp_probes,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid
);
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r2_not_ready_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r3_probe_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_probes >= CNT_W'(1)) && (resp_probes <= CNT_W'(WAYS)));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r4_fill_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

    a_r5_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid |=> !mem_req && resp_valid && !resp_hit);

    a_r5_miss_uses_all_probes: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> resp_probes == CNT_W'(WAYS));
endmodule

bind psa_cache psa_cache_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_probes (resp_probes),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid)
);

// File: tb/sim_psa_cache.sv
`timescale 1ns/1ps
module sim_psa_cache;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WAYS   = 4;
    localparam int CNT_W  = $clog2(WAYS) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid;
    logic              resp_hit;
    logic [DATA_W-1:0] resp_data;
    logic [CNT_W-1:0]  resp_probes;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_valid = 1'b0;
    logic [DATA_W-1:0] mem_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    psa_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCKS(16), .WAYS(WAYS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .resp_probes(resp_probes),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    // {addr[11:0], expected hit, expected probes[2:0]}; set = addr[1:0]
    localparam logic [15:0] VEC [0:17] = '{
        {12'h001, 1'b0, 3'd4},  // empty set: fill way0
        {12'h001, 1'b1, 3'd1},
        {12'h005, 1'b0, 3'd4},  // fill way1 (first empty)
        {12'h005, 1'b1, 3'd2},  // promote to way0
        {12'h005, 1'b1, 3'd1},
        {12'h001, 1'b1, 3'd2},  // 001 was pushed to way1
        {12'h009, 1'b0, 3'd4},  // fill way2
        {12'h00D, 1'b0, 3'd4},  // fill way3
        {12'h00D, 1'b1, 3'd4},  // last probe, promote
        {12'h001, 1'b1, 3'd4},  // 001 was swapped into way3
        {12'h011, 1'b0, 3'd4},  // full set: overwrite way0 (001)
        {12'h001, 1'b0, 3'd4},  // evicted, refills way0
        {12'h011, 1'b0, 3'd4},
        {12'h009, 1'b1, 3'd3},
        {12'h011, 1'b1, 3'd3},  // pushed to way2
        {12'h101, 1'b0, 3'd4},  // same low bits, other tag
        {12'h002, 1'b0, 3'd4},  // another set
        {12'h101, 1'b1, 3'd1}
    };

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {8'h5A, 12'h3C0, a};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input bit exp_hit,
                          input int exp_probes);
        int n = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (n < 40) begin
            if (n == 0) begin
                // sampled one cycle after the accepting edge
            end
            @(negedge clk);
            n++;
            if (n == 1 && !(exp_hit && exp_probes == 1))
                check(req_ready == 1'b0, "R2 busy after accept", 32'(req_ready), 32'd0);
            if (resp_valid || mem_req) break;
        end
        if (exp_hit) begin
            check(resp_valid == 1'b1, "R3 R7 hit response", 32'(resp_valid), 32'd1);
            check(n == exp_probes, "R3 R7 hit latency", 32'(n), 32'(exp_probes));
            check(resp_hit == 1'b1, "R3 R8 hit flag", 32'(resp_hit), 32'd1);
            check(int'(resp_probes) == exp_probes, "R3 R7 probe count",
                  32'(resp_probes), 32'(exp_probes));
            check(resp_data == mem_word(a), "R9 hit data", resp_data, mem_word(a));
        end else begin
            check(mem_req == 1'b1 && resp_valid == 1'b0, "R4 R8 full miss",
                  32'(mem_req), 32'd1);
            check(n == WAYS, "R4 miss request timing", 32'(n), 32'(WAYS));
            check(mem_addr == a, "R4 fill address", 32'(mem_addr), 32'(a));
            repeat (2) begin
                @(negedge clk);
                check(mem_req == 1'b1 && mem_addr == a, "R4 request held",
                      32'(mem_req), 32'd1);
            end
            mem_valid = 1'b1;
            mem_data  = mem_word(a);
            @(negedge clk);
            mem_valid = 1'b0;
            mem_data  = '0;
            check(resp_valid == 1'b1 && resp_hit == 1'b0, "R5 R6 fill response",
                  32'({resp_valid, resp_hit}), 32'b10);
            check(int'(resp_probes) == WAYS, "R5 miss probe count",
                  32'(resp_probes), 32'(WAYS));
            check(resp_data == mem_word(a), "R5 R9 fill data", resp_data, mem_word(a));
            check(mem_req == 1'b0, "R5 request dropped", 32'(mem_req), 32'd0);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        check(resp_valid == 1'b0, "R1 reset resp_valid", 32'(resp_valid), 32'd0);
        check(mem_req == 1'b0, "R1 reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 18; i++) begin
            access(VEC[i][15:4], VEC[i][3], int'(VEC[i][2:0]));
        end

        // R1: a mid-run reset empties every line again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(12'h101, 1'b0, 4);
        // R6: way0 now taken, so the next fill in this set lands in way1
        access(12'h001, 1'b0, 4);
        access(12'h001, 1'b1, 2);
        // R8: the two tags stay distinct
        access(12'h101, 1'b1, 2);
        // R9: other set untouched by the above
        access(12'h00E, 1'b0, 4);
        access(12'h00E, 1'b1, 1);

        repeat (2) @(negedge clk);
        summary();
    end
endmodule